// File: doc/BRIEF.md
# Background Temperature-Sensor Poll Arbiter

This block sits between software and a shared serial-bus command engine that serves a set of on-module temperature sensors. While polling is enabled, it reads the temperature of every populated sensor slot by itself. It issues one read per expiry of a programmable interval counter, and it visits the populated slots in ascending order, wrapping back to the lowest. Each result is stored in a temperature register for that slot.

To use the bus, software clears the enable bit and raises its request. The grant appears only once the engine is idle and any poll already in flight has completed. A lock input can hold the effective enable at 1, which keeps software off the bus. No poll is started while the engine reports a bus error. Every poll command tells the engine whether to write the sensor's register pointer first or to read through the pointer it already holds.

Top module: `tsense_poll_arb`

## Requirements
- R1: After reset, no command is issued, `last_slot` reads NSLOT-1 (6 by default), all temperature registers read 0, the interval counter is 0 and no poll is in flight.
- R2: `poll_en_eff` equals `poll_en_wr OR poll_lock`. While the lock is high, a 0 written to the enable still reads back as 1 and polling continues.
- R3: While enabled, the interval counter drops by one each cycle down to 0. A poll is started in a cycle where the counter is 0 and the bus is free, and the counter then reloads from `rate_reload`. `cmd_valid` is a one-cycle pulse in the cycle after the start.
- R4: Only slots whose bit in `slot_mask` is 1 are polled (bit i is slot i). The next slot is the first populated slot above the last polled one, wrapping to slot 0. An all-zero mask issues no poll.
- R5: No poll starts while `eng_err` or `eng_busy` is 1, or while an earlier poll of this block is still in flight. The counter waits at 0 until the poll can start.
- R6: `cmd_ptr_wr` is 1 when `ptr_sel` was 0 in the cycle the poll started, meaning a pointer write comes before the read. It is 0 when `ptr_sel` was 1, meaning a direct read.
- R7: When `eng_done` is 1 while a poll is in flight, `eng_rdata` is stored into the polled slot's temperature register, but only if `eng_err` is 0. Either way the poll stops being in flight.
- R8: `last_slot` (3 bits by default) changes only with `cmd_valid`, and then it equals `cmd_slot`.
- R9: While the effective enable is 0, the counter holds `rate_reload`. After re-enabling, the first poll therefore waits a full reload interval.
- R10: `sw_grant` equals `sw_req AND NOT poll_en_eff AND NOT eng_busy AND no poll in flight`.
- R11: An `eng_done` pulse while no poll is in flight leaves every temperature register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_en_wr | input | 1 | Software-written poll enable |
| poll_lock | input | 1 | Forces the effective enable to 1 |
| slot_mask | input | NSLOT | Populated-slot mask, bit i is slot i |
| rate_reload | input | RATE_W | Interval counter reload value |
| ptr_sel | input | 1 | 1 means read through the stored pointer |
| eng_busy | input | 1 | Engine busy |
| eng_err | input | 1 | Engine bus-error flag |
| eng_done | input | 1 | Engine read-complete pulse |
| eng_rdata | input | TEMP_W | Engine read data |
| sw_req | input | 1 | Software bus request |
| poll_en_eff | output | 1 | Effective enable, as read back |
| sw_grant | output | 1 | Bus granted to software |
| cmd_valid | output | 1 | Poll command pulse |
| cmd_slot | output | SLOT_W | Slot addressed by the command |
| cmd_ptr_wr | output | 1 | Pointer write precedes the read |
| last_slot | output | SLOT_W | Most recently polled slot |
| temp_flat | output | NSLOT*TEMP_W | Temperature registers, slot i at bits i*TEMP_W |

## Verification
A wrong slot pointer shows on `cmd_slot` at the very next poll, which comes at most reload+1 cycles after the bus frees up. A stuck in-flight flag shows the same way: either polls stop, or `sw_grant` is refused or given at the wrong time. Counter faults shift when `cmd_valid` pulses, and the cycle-exact reference model catches that on the first mistimed cycle. A faulty capture shows in `temp_flat` in the cycle after `eng_done`.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    localparam int unsigned TSP_NSLOT_DEF = 7;
    localparam int unsigned TSP_TEMP_W_DEF = 16;
    localparam int unsigned TSP_RATE_W_DEF = 16;

    // modular successor used when scanning slots
    function automatic int unsigned tsp_wrap(input int unsigned a, input int unsigned n);
        return a % n;
    endfunction
endpackage

// File: rtl/tsp_rate_timer.sv
module tsp_rate_timer #(
    parameter int unsigned RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fire,
    input  logic [RATE_W-1:0] reload,
    output logic              zero
);
    logic [RATE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || fire) begin
            cnt_d = reload;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R3
    fire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> cnt_q == '0);
endmodule

// File: rtl/tsp_slot_pick.sv
module tsp_slot_pick import tsp_pkg::*; #(
    parameter int unsigned NSLOT  = 7,
    parameter int unsigned SLOT_W = 3
) (
    input  logic [NSLOT-1:0]  mask,
    input  logic [SLOT_W-1:0] last,
    output logic [SLOT_W-1:0] pick,
    output logic              any
);
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= int'(NSLOT); k++) begin
            int unsigned s;
            s = tsp_wrap(int'(last) + k, NSLOT);
            if (!found && mask[s]) begin
                pick  = SLOT_W'(s);
                found = 1'b1;
            end
        end
        any = |mask;
    end
endmodule

// File: rtl/tsense_poll_arb.sv
module tsense_poll_arb import tsp_pkg::*; #(
    parameter int unsigned NSLOT  = TSP_NSLOT_DEF,
    parameter int unsigned TEMP_W = TSP_TEMP_W_DEF,
    parameter int unsigned RATE_W = TSP_RATE_W_DEF,
    localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    poll_en_wr,
    input  logic                    poll_lock,
    input  logic [NSLOT-1:0]        slot_mask,
    input  logic [RATE_W-1:0]       rate_reload,
    input  logic                    ptr_sel,
    input  logic                    eng_busy,
    input  logic                    eng_err,
    input  logic                    eng_done,
    input  logic [TEMP_W-1:0]       eng_rdata,
    input  logic                    sw_req,
    output logic                    poll_en_eff,
    output logic                    sw_grant,
    output logic                    cmd_valid,
    output logic [SLOT_W-1:0]       cmd_slot,
    output logic                    cmd_ptr_wr,
    output logic [SLOT_W-1:0]       last_slot,
    output logic [NSLOT*TEMP_W-1:0] temp_flat
);
    typedef struct packed {
        logic                         cv;
        logic [SLOT_W-1:0]            slot;
        logic                         ptrw;
        logic                         inf;
        logic [SLOT_W-1:0]            last;
        logic [NSLOT-1:0][TEMP_W-1:0] temp;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic tmr_zero, any_pop, issue;
    logic [SLOT_W-1:0] pick;

    assign poll_en_eff = poll_en_wr | poll_lock;
    assign issue = poll_en_eff & tmr_zero & ~eng_busy & ~eng_err & ~st_q.inf & any_pop;

    tsp_rate_timer #(.RATE_W(RATE_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .en(poll_en_eff), .fire(issue),
        .reload(rate_reload), .zero(tmr_zero)
    );

    tsp_slot_pick #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) pick_i (
        .mask(slot_mask), .last(st_q.last), .pick(pick), .any(any_pop)
    );

    always_comb begin
        st_d    = st_q;
        st_d.cv = issue;
        if (st_q.inf && eng_done) begin
            st_d.inf = 1'b0;
            if (!eng_err) st_d.temp[st_q.last] = eng_rdata;
        end
        if (issue) begin
            st_d.slot = pick;
            st_d.last = pick;
            st_d.ptrw = ~ptr_sel;
            st_d.inf  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= SLOT_W'(NSLOT-1);
        end else begin
            st_q <= st_d;
        end
    end

    assign sw_grant   = sw_req & ~poll_en_eff & ~eng_busy & ~st_q.inf;
    assign cmd_valid  = st_q.cv;
    assign cmd_slot   = st_q.slot;
    assign cmd_ptr_wr = st_q.ptrw;
    assign last_slot  = st_q.last;
    assign temp_flat  = st_q.temp;

    // R5
    no_issue_in_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(!eng_err && !eng_busy));
    // R4
    slot_populated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((($past(slot_mask)) >> cmd_slot) & NSLOT'(1)) != '0);
    // R10
    grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_grant |-> !cmd_valid);
    // R8
    last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable(last_slot));
    // R5
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
endmodule

// File: tb/tsense_poll_arb_tb_top.sv
module tsense_poll_arb_tb_top;
    localparam int N = 7;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic poll_en_wr = 0, poll_lock = 0, ptr_sel = 0;
    logic [N-1:0] slot_mask = '0;
    logic [15:0] rate_reload = 16'd5;
    logic eng_busy = 0, eng_err = 0, eng_done = 0, sw_req = 0;
    logic [TW-1:0] eng_rdata = '0;
    logic poll_en_eff, sw_grant, cmd_valid, cmd_ptr_wr;
    logic [2:0] cmd_slot, last_slot;
    logic [N*TW-1:0] temp_flat;

    int vecs = 0, miss = 0;

    always #5 clk = ~clk;

    tsense_poll_arb dut_i (
        .clk(clk), .rst_n(rst_n), .poll_en_wr(poll_en_wr), .poll_lock(poll_lock),
        .slot_mask(slot_mask), .rate_reload(rate_reload), .ptr_sel(ptr_sel),
        .eng_busy(eng_busy), .eng_err(eng_err), .eng_done(eng_done),
        .eng_rdata(eng_rdata), .sw_req(sw_req), .poll_en_eff(poll_en_eff),
        .sw_grant(sw_grant), .cmd_valid(cmd_valid), .cmd_slot(cmd_slot),
        .cmd_ptr_wr(cmd_ptr_wr), .last_slot(last_slot), .temp_flat(temp_flat)
    );

    // behavioural reference model
    int m_cnt, m_last, m_slot, m_inf;
    bit m_cv, m_ptrw;
    logic [TW-1:0] m_temp [N];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_last = N-1; m_slot = 0; m_inf = 0; m_cv = 0; m_ptrw = 0;
            for (int i = 0; i < N; i++) m_temp[i] = '0;
        end else begin
            bit en, go;
            int nxt;
            en = poll_en_wr || poll_lock;
            go = en && m_cnt == 0 && !eng_busy && !eng_err && m_inf == 0 && slot_mask != 0;
            nxt = -1;
            for (int k = 1; k <= N; k++)
                if (nxt < 0 && slot_mask[(m_last + k) % N]) nxt = (m_last + k) % N;
            if (m_inf != 0 && eng_done) begin
                if (!eng_err) m_temp[m_last] = eng_rdata;
                m_inf = 0;
            end
            if (!en || go) m_cnt = rate_reload;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_cv = go;
            if (go) begin
                m_slot = nxt; m_last = nxt; m_ptrw = !ptr_sel; m_inf = 1;
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        vecs++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit exp_en;
        exp_en = poll_en_wr || poll_lock;
        chk("R2 poll_en_eff", poll_en_eff, exp_en);
        chk("R10 sw_grant", sw_grant, sw_req && !exp_en && !eng_busy && m_inf == 0);
        chk("R3 R5 R9 cmd_valid", cmd_valid, m_cv);
        if (m_cv) begin
            chk("R4 cmd_slot", cmd_slot, m_slot);
            chk("R6 cmd_ptr_wr", cmd_ptr_wr, m_ptrw);
        end
        chk("R8 last_slot", last_slot, m_last);
        for (int i = 0; i < N; i++)
            chk("R7 R11 temp", temp_flat[i*TW +: TW], m_temp[i]);
    endtask

    int e_cnt = 0, s_cnt = 0, e_slot = 0;

    task automatic drive_engine(input int c);
        bit dn;
        dn = 0;
        if (cmd_valid) begin
            e_cnt = 3; e_slot = cmd_slot;
        end else if (e_cnt > 0) begin
            e_cnt--;
            if (e_cnt == 0) begin
                dn = 1;
                eng_rdata = 16'h0A00 + TW'(e_slot * 16) + TW'(c & 15);
            end
        end
        if (sw_grant && s_cnt == 0) s_cnt = 4;
        else if (s_cnt > 0) s_cnt--;
        if (c == 640) begin  // R11: stray completion, nothing in flight
            dn = 1; eng_rdata = 16'hDEAD;
        end
        eng_busy = (e_cnt > 0) || (s_cnt > 0);
        eng_done = dn;
    endtask

    task automatic stimulus(input int c);
        case (c)
            3:   rst_n = 1'b1;
            4:   begin poll_en_wr = 1; slot_mask = 7'b0101101; rate_reload = 16'd5; end
            300: eng_err = 1;      // R5
            330: eng_err = 0;
            400: begin slot_mask = 7'b1000010; ptr_sel = 1; end  // R6
            500: slot_mask = '0;   // R4 empty mask
            520: begin slot_mask = 7'h7F; rate_reload = 16'd3; end
            600: begin poll_en_wr = 0; sw_req = 1; end          // R10
            650: poll_lock = 1;    // R2
            700: begin poll_lock = 0; sw_req = 0; poll_en_wr = 1; rate_reload = 16'd7; end // R9
            850: eng_err = 1;      // R7 error at completion
            853: eng_err = 0;
            900: rate_reload = 16'd0;
            default: ;
        endcase
    endtask

    initial begin
        for (int c = 0; c < 1000; c++) begin
            @(negedge clk);
            if (c == 2) begin  // R1 reset state
                chk("R1 cmd_valid", cmd_valid, 0);
                chk("R1 last_slot", last_slot, N-1);
                chk("R1 temp", temp_flat, 0);
                chk("R1 sw_grant", sw_grant, 0);
            end
            if (rst_n) compare();
            drive_engine(c);
            stimulus(c);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        #2000000;
        miss++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule